// File: doc/BRIEF.md
# Reversible 5/3 Lifting Wavelet Datapath

This block is a streaming datapath for the integer 5/3 lifting wavelet. It works in both directions. Samples arrive as pairs, one pair per valid cycle. In the forward direction a pair is an even and an odd sample, and the block returns a low-band and high-band coefficient for each pair. In the inverse direction it takes low/high coefficient pairs and rebuilds the even/odd samples. The arithmetic uses only adders and arithmetic shifts. No multiplier is used.

The logic is split into two partitions that work in the same cycle. The odd partition does the predict step: it forms a half-sum of two evens and adds it to, or subtracts it from, the odd value. The even partition does the update step: it forms a rounded quarter-sum of two high values. A small register file holds the pending pair, the previous high value and the line markers. A line is framed by a first flag and a last flag. At both ends of the line, a missing neighbour is replaced by its mirror sample. A pair's result is ready only once the next pair of the line has arrived. For this reason the output trails the input by one pair, and the last pair is drained on its own in the following cycle.

Top module: `lift53_core`

## Requirements
- R1: With `inv_mode`=0, `in_a` carries even[n] and `in_b` carries odd[n]. `out_b` gives high[n] = odd[n] − floor((even[n]+even[n+1])/2).
- R2: With `inv_mode`=0, `out_a` gives low[n] = even[n] + floor((high[n]+high[n−1]+2)/4).
- R3: With `inv_mode`=1, `in_a`/`in_b` carry low[n]/high[n]. `out_a` gives even[n] = low[n] − floor((high[n]+high[n−1]+2)/4), and `out_b` gives odd[n] = high[n] + floor((even[n]+even[n+1])/2).
- R4: At the line ends, high[−1] is taken equal to high[0], and even[N] is taken equal to even[N−1]. This also applies to a line of a single pair. Example: forward (3,8) gives low 6, high 5, and forward (−3,−8) gives low −5, high −5.
- R5: The result for pair n−1 of a line is visible one cycle after pair n is accepted. The result for the last pair is visible two cycles after that pair is accepted, whatever the input does in between.
- R6: `out_first` marks the result of the first pair of a line, and `out_last` marks the result of the last pair. Results leave in input order.
- R7: Cycles with `in_valid`=0 produce no result, except a pending drain. They leave the line state untouched.
- R8: While `rst` is high, and in the cycle after it, `out_valid` is 0 and no pair is pending.
- R9: All values are DW-bit two's complement and wrap modulo 2^DW. A forward pass followed by an inverse pass gives back the input exactly for any input values.
- R10: The first pair of a new line may arrive in the cycle right after the last pair of the previous line. A non-first pair is only allowed while a pair of the same line is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inv_mode | input | 1 | 0 = forward, 1 = inverse; held constant within a line |
| in_valid | input | 1 | A sample pair is presented |
| in_first | input | 1 | Pair is the first of its line |
| in_last | input | 1 | Pair is the last of its line |
| in_a | input | DW | Even sample (forward) or low coefficient (inverse) |
| in_b | input | DW | Odd sample (forward) or high coefficient (inverse) |
| out_valid | output | 1 | A result pair is presented |
| out_first | output | 1 | Result belongs to the first pair of a line |
| out_last | output | 1 | Result belongs to the last pair of a line |
| out_a | output | DW | Low coefficient (forward) or even sample (inverse) |
| out_b | output | DW | High coefficient (forward) or odd sample (inverse) |

## Verification
The bench builds the block with DW=12. With that width, fully random samples often push the half-sums and quarter-sums past the port width. This exercises the modular wrap and the exactness of the inverse at the extremes. Lines run from one pair up to 32 pairs. This covers the single-pair case, where both mirror rules apply to the same pair. It also covers long lines with random idle gaps and lines sent back to back that switch direction at the boundary.

// File: rtl/lift53_pkg.sv
`timescale 1ns/1ps
package lift53_pkg;

    typedef enum logic {
        MODE_FWD = 1'b0,
        MODE_INV = 1'b1
    } mode_e;

    // Line markers kept alongside the pending pair
    typedef struct packed {
        logic  first;
        logic  last;
        mode_e mode;
    } line_tag_t;

endpackage

// File: rtl/lift53_predict.sv
`timescale 1ns/1ps
// Odd partition: base -/+ floor((e_cur + e_nxt) / 2)
module lift53_predict
    import lift53_pkg::*;
#(
    parameter int DW = 16
) (
    input  mode_e                mode,
    input  logic signed [DW-1:0] base,
    input  logic signed [DW-1:0] e_cur,
    input  logic signed [DW-1:0] e_nxt,
    output logic signed [DW-1:0] res
);
    localparam int SW = DW + 1;

    logic signed [SW-1:0] half;

    always_comb begin
        half = (SW'(e_cur) + SW'(e_nxt)) >>> 1;
        if (mode == MODE_INV)
            res = DW'(SW'(base) + half);
        else
            res = DW'(SW'(base) - half);
    end
endmodule

// File: rtl/lift53_update.sv
`timescale 1ns/1ps
// Even partition: base +/- floor((h_cur + h_prv + 2) / 4)
module lift53_update
    import lift53_pkg::*;
#(
    parameter int DW = 16
) (
    input  mode_e                mode,
    input  logic signed [DW-1:0] base,
    input  logic signed [DW-1:0] h_cur,
    input  logic signed [DW-1:0] h_prv,
    output logic signed [DW-1:0] res
);
    localparam int UW = DW + 2;

    logic signed [UW-1:0] quarter;

    always_comb begin
        quarter = (UW'(h_cur) + UW'(h_prv) + UW'(2)) >>> 2;
        if (mode == MODE_INV)
            res = DW'(UW'(base) - quarter);
        else
            res = DW'(UW'(base) + quarter);
    end
endmodule

// File: rtl/lift53_hist.sv
`timescale 1ns/1ps
// Register file: pending pair, previous high value, line markers
module lift53_hist
    import lift53_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 drain,
    input  logic signed [DW-1:0] new_e,
    input  logic signed [DW-1:0] new_x,
    input  line_tag_t            new_tag,
    input  logic                 h_we,
    input  logic signed [DW-1:0] h_new,
    output logic                 pend_valid,
    output logic signed [DW-1:0] pend_e,
    output logic signed [DW-1:0] pend_x,
    output logic signed [DW-1:0] hist_h,
    output line_tag_t            pend_tag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_e     <= '0;
            pend_x     <= '0;
            hist_h     <= '0;
            pend_tag   <= '{first: 1'b0, last: 1'b0, mode: MODE_FWD};
        end else begin
            if (load) begin
                pend_valid <= 1'b1;
                pend_e     <= new_e;
                pend_x     <= new_x;
                pend_tag   <= new_tag;
            end else if (drain) begin
                pend_valid <= 1'b0;
            end
            if (h_we)
                hist_h <= h_new;
        end
    end
endmodule

// File: rtl/lift53_core.sv
`timescale 1ns/1ps
module lift53_core
    import lift53_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 inv_mode,
    input  logic                 in_valid,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic signed [DW-1:0] in_a,
    input  logic signed [DW-1:0] in_b,
    output logic                 out_valid,
    output logic                 out_first,
    output logic                 out_last,
    output logic signed [DW-1:0] out_a,
    output logic signed [DW-1:0] out_b
);
    logic                 pend_valid;
    logic signed [DW-1:0] pend_e, pend_x, hist_h;
    line_tag_t            pend_tag, new_tag;
    mode_e                in_mode, op_mode;
    logic                 drain, emit_mid, emit;
    logic signed [DW-1:0] e_rec, e_nxt, pred, low, h_prv_f, h_prv_i, load_e;

    assign in_mode  = mode_e'(inv_mode);
    assign new_tag  = '{first: in_first, last: in_last, mode: in_mode};
    assign drain    = pend_valid && pend_tag.last;
    assign emit_mid = in_valid && !in_first && pend_valid;
    assign emit     = emit_mid || drain;
    assign op_mode  = drain ? pend_tag.mode : in_mode;

    // Inverse: rebuild even[n] as soon as its pair arrives
    assign h_prv_i = in_first ? in_b : pend_x;
    lift53_update #(.DW(DW)) u_upd_inv (
        .mode(MODE_INV), .base(in_a), .h_cur(in_b), .h_prv(h_prv_i), .res(e_rec)
    );

    // Right neighbour of the pending even value, mirrored at line end
    always_comb begin
        if (drain)
            e_nxt = pend_e;
        else if (op_mode == MODE_INV)
            e_nxt = e_rec;
        else
            e_nxt = in_a;
    end

    lift53_predict #(.DW(DW)) u_pred (
        .mode(op_mode), .base(pend_x), .e_cur(pend_e), .e_nxt(e_nxt), .res(pred)
    );

    // Forward update follows predict; left neighbour mirrored at line start
    assign h_prv_f = pend_tag.first ? pred : hist_h;
    lift53_update #(.DW(DW)) u_upd_fwd (
        .mode(MODE_FWD), .base(pend_e), .h_cur(pred), .h_prv(h_prv_f), .res(low)
    );

    assign load_e = (in_mode == MODE_INV) ? e_rec : in_a;

    lift53_hist #(.DW(DW)) u_hist (
        .clk(clk), .rst(rst), .load(in_valid), .drain(drain),
        .new_e(load_e), .new_x(in_b), .new_tag(new_tag),
        .h_we(emit), .h_new(pred),
        .pend_valid(pend_valid), .pend_e(pend_e), .pend_x(pend_x),
        .hist_h(hist_h), .pend_tag(pend_tag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            out_a     <= '0;
            out_b     <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_first <= pend_tag.first;
                out_last  <= drain;
                out_a     <= (op_mode == MODE_INV) ? pend_e : low;
                out_b     <= pred;
            end
        end
    end

    // R8
    reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R5
    mid_emit_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_first |=> out_valid && !out_last);

    // R5
    drain_emit_chk: assert property (@(posedge clk) disable iff (rst)
        pend_valid && pend_tag.last |=> out_valid && out_last);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid && !(pend_valid && pend_tag.last) |=> !out_valid);

    // R10
    mid_line_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_first |-> pend_valid && !pend_tag.last);

    // R6
    line_order_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_last |=> !out_valid || out_first);
endmodule

// File: tb/lift53_core_bench.sv
`timescale 1ns/1ps
module lift53_core_bench;
    localparam int DW   = 12;
    localparam int MAXN = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inv_mode = 1'b0, in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic signed [DW-1:0] in_a = '0, in_b = '0;
    logic out_valid, out_first, out_last;
    logic signed [DW-1:0] out_a, out_b;

    lift53_core #(.DW(DW)) u_lift53_core (
        .clk(clk), .rst(rst), .inv_mode(inv_mode), .in_valid(in_valid),
        .in_first(in_first), .in_last(in_last), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
        .out_a(out_a), .out_b(out_b)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    int ia[2][MAXN], ib[2][MAXN], ea[2][MAXN], eb[2][MAXN], istamp[2][MAXN];
    int nlen[2];
    int la[256], lb[256], lf[256], ll[256], ls[256];
    int lcnt = 0;

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            la[lcnt % 256] = int'(out_a);
            lb[lcnt % 256] = int'(out_b);
            lf[lcnt % 256] = int'(out_first);
            ll[lcnt % 256] = int'(out_last);
            ls[lcnt % 256] = cyc;
            lcnt++;
        end
    end

    function automatic int wrap(int v);
        int m = v & ((1 << DW) - 1);
        if (m >= (1 << (DW - 1))) m -= (1 << DW);
        return m;
    endfunction

    function automatic int rnd();
        return wrap(int'($urandom % (1 << DW)));
    endfunction

    task automatic ref_fwd(int s);
        int n = nlen[s];
        int h[MAXN];
        for (int k = 0; k < n; k++) begin
            int ne = (k == n - 1) ? ia[s][k] : ia[s][k+1];
            h[k] = wrap(ib[s][k] - ((ia[s][k] + ne) >>> 1));
        end
        for (int k = 0; k < n; k++) begin
            int hp = (k == 0) ? h[0] : h[k-1];
            ea[s][k] = wrap(ia[s][k] + ((h[k] + hp + 2) >>> 2));
            eb[s][k] = h[k];
        end
    endtask

    task automatic ref_inv(int s);
        int n = nlen[s];
        int e[MAXN];
        for (int k = 0; k < n; k++) begin
            int hp = (k == 0) ? ib[s][0] : ib[s][k-1];
            e[k] = wrap(ia[s][k] - ((ib[s][k] + hp + 2) >>> 2));
        end
        for (int k = 0; k < n; k++) begin
            int ne = (k == n - 1) ? e[k] : e[k+1];
            ea[s][k] = e[k];
            eb[s][k] = wrap(ib[s][k] + ((e[k] + ne) >>> 1));
        end
    endtask

    task automatic idle(int k);
        repeat (k) begin
            @(negedge clk); #1;
            in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        end
    endtask

    task automatic send_line(int s, bit inv, bit gapped);
        for (int k = 0; k < nlen[s]; k++) begin
            if (gapped && k > 0 && ($urandom % 2) == 1) idle(1 + int'($urandom % 3));
            @(negedge clk); #1;
            in_valid = 1'b1; inv_mode = inv;
            in_first = (k == 0); in_last = (k == nlen[s] - 1);
            in_a = DW'(ia[s][k]); in_b = DW'(ib[s][k]);
            istamp[s][k] = cyc;
        end
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_line(int s, int base, string req);
        int n = nlen[s];
        check(lcnt - base >= n, req, "result count", lcnt - base, n);
        for (int k = 0; k < n; k++) begin
            int i = (base + k) % 256;
            int st = (k < n - 1) ? istamp[s][k+1] + 1 : istamp[s][n-1] + 2;
            check(la[i] == ea[s][k], req, $sformatf("out_a pair %0d", k), la[i], ea[s][k]);
            check(lb[i] == eb[s][k], req, $sformatf("out_b pair %0d", k), lb[i], eb[s][k]);
            // R6 markers, R5 timing
            check(lf[i] == int'(k == 0) && ll[i] == int'(k == n - 1), "R6",
                  $sformatf("markers pair %0d", k), lf[i] * 2 + ll[i],
                  int'(k == 0) * 2 + int'(k == n - 1));
            check(ls[i] == st, "R5", $sformatf("timing pair %0d", k), ls[i], st);
        end
    endtask

    task automatic run_fwd(int s, bit gapped, string req);
        int base = lcnt;
        ref_fwd(s);
        send_line(s, 1'b0, gapped);
        idle(4);
        check_line(s, base, req);
    endtask

    task automatic run_inv(int s, bit gapped, string req);
        int base = lcnt;
        ref_inv(s);
        send_line(s, 1'b1, gapped);
        idle(4);
        check_line(s, base, req);
    endtask

    task automatic roundtrip(int n, bit gapped);
        int base;
        nlen[0] = n;
        for (int k = 0; k < n; k++) begin ia[0][k] = rnd(); ib[0][k] = rnd(); end
        base = lcnt;
        run_fwd(0, gapped, "R1 R2");
        nlen[1] = n;
        for (int k = 0; k < n; k++) begin
            ia[1][k] = la[(base + k) % 256];
            ib[1][k] = lb[(base + k) % 256];
        end
        base = lcnt;
        send_line(1, 1'b1, gapped);
        idle(4);
        // R9: expected is the original forward input
        for (int k = 0; k < n; k++) begin ea[1][k] = ia[0][k]; eb[1][k] = ib[0][k]; end
        check_line(1, base, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(32'd5317));
        repeat (3) @(negedge clk);
        // R8: outputs quiet under reset
        check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
        @(negedge clk); #1; rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);

        // R4 single pair, directed values
        nlen[0] = 1; ia[0][0] = 3; ib[0][0] = 8;
        base = lcnt; send_line(0, 1'b0, 1'b0); idle(4);
        check(la[base % 256] == 6 && lb[base % 256] == 5, "R4", "single pair (3,8)",
              la[base % 256] * 100 + lb[base % 256], 605);
        ia[0][0] = -3; ib[0][0] = -8;
        base = lcnt; send_line(0, 1'b0, 1'b0); idle(4);
        check(la[base % 256] == -5 && lb[base % 256] == -5, "R4", "single pair (-3,-8)",
              la[base % 256], -5);

        // R1 R2 ramp and constant lines
        nlen[0] = 4;
        for (int k = 0; k < 4; k++) begin ia[0][k] = 2 * k; ib[0][k] = 2 * k + 1; end
        run_fwd(0, 1'b0, "R1 ramp");
        for (int k = 0; k < 4; k++) begin ia[0][k] = 5; ib[0][k] = 5; end
        run_fwd(0, 1'b0, "R2 constant");

        // R3 directed inverse
        nlen[0] = 3;
        ia[0][0] = 10; ib[0][0] = -4; ia[0][1] = -7; ib[0][1] = 9; ia[0][2] = 0; ib[0][2] = 1;
        run_inv(0, 1'b0, "R3");

        // R7 gaps inside a line
        nlen[0] = 12;
        for (int k = 0; k < 12; k++) begin ia[0][k] = rnd(); ib[0][k] = rnd(); end
        run_fwd(0, 1'b1, "R7 fwd");
        run_inv(0, 1'b1, "R7 inv");
        // R7: idle cycles produce nothing
        base = lcnt; idle(5);
        check(lcnt == base, "R7", "results during idle", lcnt - base, 0);

        // R10 back-to-back lines, direction switch at the boundary
        nlen[0] = 5; nlen[1] = 4;
        for (int k = 0; k < 5; k++) begin ia[0][k] = rnd(); ib[0][k] = rnd(); end
        for (int k = 0; k < 4; k++) begin ia[1][k] = rnd(); ib[1][k] = rnd(); end
        ref_fwd(0); ref_inv(1);
        base = lcnt;
        send_line(0, 1'b0, 1'b0);
        send_line(1, 1'b1, 1'b0);
        idle(4);
        check_line(0, base, "R10 line A");
        check_line(1, base + 5, "R10 line B");

        // R9 full-range round trips
        for (int t = 0; t < 24; t++)
            roundtrip(1 + int'($urandom % MAXN), t[0]);
        // R9 extremes
        nlen[0] = 6;
        for (int k = 0; k < 6; k++) begin
            ia[0][k] = k[0] ? -(1 << (DW - 1)) : (1 << (DW - 1)) - 1;
            ib[0][k] = k[0] ? (1 << (DW - 1)) - 1 : -(1 << (DW - 1));
        end
        run_fwd(0, 1'b0, "R9 extremes");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule